// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Unit

This unit executes the four bit-manipulation instructions for control and status registers: set bits or clear bits, each with a mask that comes either from a source register value or from a 5-bit immediate. For each request it decodes the 12-bit CSR address against a small table of implemented registers and checks access rights against the current privilege level. It returns the value the register held before the instruction, and when the instruction intends to write, it stores that old value with the mask applied.

The implemented set is small on purpose. It holds a machine scratch register, a supervisor scratch register, a user-writable scratch register, 29 machine counter high halves, read-only user aliases of those high halves, and a read-only machine hart identifier. A request is answered one clock edge after it is presented. The answer is either a destination-register write or an exception that carries the failing instruction word. Field legalization inside individual registers is not modelled.

Top module: `csr_rmw_unit`

## Requirements
- R1: A request presented with `reqValid` high is answered on the next rising clock edge. If there is no exception, `rdData` carries the CSR value read before any change, `rdIdx` echoes `reqRdIdx`, and `rdWe` is high. `reqOp` encodes 0 = set/register, 1 = clear/register, 2 = set/immediate, 3 = clear/immediate.
- R2: The set forms store old value OR mask. The stored value is visible to the next request.
- R3: The clear forms store old value AND NOT mask.
- R4: In the immediate forms the mask is `reqSrcIdx` zero-extended to XLEN, and `reqSrcVal` is ignored.
- R5: The write intent depends only on `reqSrcIdx` being non-zero. With index zero the register is read and left unchanged, whatever `reqSrcVal` holds.
- R6: The implemented addresses are 0x340, 0x140, 0x800, 0xB83–0xB9F, 0xC83–0xC9F and 0xF14. Any other address raises an exception with `excReason` = 1. This check has the highest priority.
- R7: Privilege encoding is 0 = user, 1 = supervisor, 3 = machine. An implemented address whose bits [9:8] exceed `privMode` raises `excReason` = 2. This check is ranked above the writability check.
- R8: An address with bits [11:10] = 2'b11 is read-only. A write intent to it raises `excReason` = 3. A plain read of it succeeds.
- R9: When an exception is raised, `excValid` is high, `excCode` = 2, `excTval` equals `reqInsn`, `rdWe` is low, and no CSR changes.
- R10: The user alias at 0xC80+n (n = 3..31) reads the value of the machine high half at 0xB80+n. Address 0xC80 through 0xC82 and 0xCA0 are unimplemented.
- R11: When `reqRdIdx` is 0, `rdWe` stays low but the CSR write still takes place.
- R12: Reset clears all writable CSRs to zero and holds `rdWe` and `excValid` low. A cycle without `reqValid` gives neither output. Address 0xF14 reads the parameter `HART_ID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | Operation select (set/clear, register/immediate) |
| reqAddr | input | 12 | CSR address |
| reqSrcIdx | input | 5 | Source register index or immediate |
| reqSrcVal | input | XLEN | Source register value |
| reqRdIdx | input | 5 | Destination register index |
| reqInsn | input | ILEN | Instruction word, reported as trap value |
| privMode | input | 2 | Current privilege level |
| rdWe | output | 1 | Destination write strobe |
| rdIdx | output | 5 | Destination register index |
| rdData | output | XLEN | Old CSR value |
| excValid | output | 1 | Exception raised |
| excCode | output | 5 | Exception cause code |
| excReason | output | 2 | Which permission check failed |
| excTval | output | ILEN | Failing instruction word |

## Verification
The main tests are chains of set and clear requests on a single register, in both register and immediate forms. Each old value returned shows the result of the previous mask, which tells OR apart from AND-NOT. Pairs that use a zero index with an all-ones value separate a write decision based on the index from one based on the operand value. In the immediate pairs, an all-ones register value is present but must not leak into the mask. Privilege and address patterns are chosen so that two checks fail together, for example an unimplemented machine address accessed from user mode, or a write to a read-only machine register from user mode. The reason code reported then shows the priority order. A later read-back of the targeted register confirms that the exception left it untouched.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  localparam int CNT_LO  = 3;
  localparam int CNT_HI  = 31;
  localparam int NUM_CNT = CNT_HI - CNT_LO + 1;

  localparam logic [11:0] ADDR_MSCR = 12'h340;
  localparam logic [11:0] ADDR_SSCR = 12'h140;
  localparam logic [11:0] ADDR_USCR = 12'h800;
  localparam logic [11:0] ADDR_HART = 12'hF14;
  localparam logic [6:0]  MCNTH_PAGE = 7'h5C; // 0xB80 >> 5
  localparam logic [6:0]  UCNTH_PAGE = 7'h64; // 0xC80 >> 5

  localparam logic [4:0]  EXC_CODE_ILLEGAL = 5'd2;

  typedef enum logic [2:0] {
    KIND_NONE, KIND_MSCR, KIND_SSCR, KIND_USCR, KIND_MCNTH, KIND_UCNTH, KIND_HART
  } csrKind_e;

  typedef enum logic [1:0] {
    EXC_NONE   = 2'd0,
    EXC_UNIMPL = 2'd1,
    EXC_MODE   = 2'd2,
    EXC_RDONLY = 2'd3
  } excReason_e;

  typedef struct packed {
    logic       respond;
    logic       wrEn;
    logic       rdWe;
    logic       excRaise;
    excReason_e reason;
    logic       clrOp;
    logic       immOp;
    csrKind_e   kind;
  } ctrlStrobe_t;

  function automatic csrKind_e csrDecode(input logic [11:0] addr);
    csrKind_e k;
    k = KIND_NONE;
    if (addr == ADDR_MSCR) k = KIND_MSCR;
    else if (addr == ADDR_SSCR) k = KIND_SSCR;
    else if (addr == ADDR_USCR) k = KIND_USCR;
    else if (addr == ADDR_HART) k = KIND_HART;
    else if (addr[11:5] == MCNTH_PAGE && addr[4:0] >= 5'(CNT_LO)) k = KIND_MCNTH;
    else if (addr[11:5] == UCNTH_PAGE && addr[4:0] >= 5'(CNT_LO)) k = KIND_UCNTH;
    return k;
  endfunction

endpackage

// File: rtl/csr_rmw_ctrl.sv
module csr_rmw_ctrl
  import csr_rmw_pkg::*;
(
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [11:0] reqAddr,
  input  logic [4:0]  reqSrcIdx,
  input  logic [4:0]  reqRdIdx,
  input  logic [1:0]  privMode,
  output ctrlStrobe_t strobe
);

  csrKind_e kind;
  logic     wantWrite;
  logic     implemented;
  logic     modeOk;
  logic     writable;

  always_comb begin
    kind        = csrDecode(reqAddr);
    wantWrite   = (reqSrcIdx != 5'd0);
    implemented = (kind != KIND_NONE);
    modeOk      = (privMode >= reqAddr[9:8]);
    writable    = (reqAddr[11:10] != 2'b11);
  end

  // fixed priority: existence, then privilege, then writability
  always_comb begin
    strobe          = '0;
    strobe.kind     = kind;
    strobe.clrOp    = reqOp[0];
    strobe.immOp    = reqOp[1];
    strobe.respond  = reqValid;
    strobe.reason   = EXC_NONE;
    if (reqValid) begin
      if (!implemented) begin
        strobe.excRaise = 1'b1;
        strobe.reason   = EXC_UNIMPL;
      end else if (!modeOk) begin
        strobe.excRaise = 1'b1;
        strobe.reason   = EXC_MODE;
      end else if (wantWrite && !writable) begin
        strobe.excRaise = 1'b1;
        strobe.reason   = EXC_RDONLY;
      end else begin
        strobe.wrEn = wantWrite;
        strobe.rdWe = (reqRdIdx != 5'd0);
      end
    end
  end

endmodule

// File: rtl/csr_rmw_dp.sv
module csr_rmw_dp
  import csr_rmw_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          ILEN    = 32,
  parameter logic [31:0] HART_ID = 32'h0000_0007
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [11:0]      reqAddr,
  input  logic [4:0]       reqSrcIdx,
  input  logic [XLEN-1:0]  reqSrcVal,
  input  logic [4:0]       reqRdIdx,
  input  logic [ILEN-1:0]  reqInsn,
  output logic             rdWe,
  output logic [4:0]       rdIdx,
  output logic [XLEN-1:0]  rdData,
  output logic             excValid,
  output logic [4:0]       excCode,
  output logic [1:0]       excReason,
  output logic [ILEN-1:0]  excTval
);

  localparam int IMM_W = 5;

  logic [XLEN-1:0] mScr, sScr, uScr;
  logic [XLEN-1:0] cntHi [NUM_CNT];
  logic [4:0]      cntSel;
  logic [XLEN-1:0] readCnt;
  logic [XLEN-1:0] oldVal;
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] newVal;

  assign cntSel = reqAddr[4:0] - 5'(CNT_LO);

  always_comb begin
    readCnt = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (cntSel == 5'(i)) readCnt = cntHi[i];
    end
  end

  always_comb begin
    unique case (strobe.kind)
      KIND_MSCR:  oldVal = mScr;
      KIND_SSCR:  oldVal = sScr;
      KIND_USCR:  oldVal = uScr;
      KIND_MCNTH,
      KIND_UCNTH: oldVal = readCnt;
      KIND_HART:  oldVal = XLEN'(HART_ID);
      default:    oldVal = '0;
    endcase
  end

  assign mask   = strobe.immOp ? {{(XLEN-IMM_W){1'b0}}, reqSrcIdx} : reqSrcVal;
  assign newVal = strobe.clrOp ? (oldVal & ~mask) : (oldVal | mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mScr <= '0;
      sScr <= '0;
      uScr <= '0;
    end else if (strobe.wrEn) begin
      if (strobe.kind == KIND_MSCR) mScr <= newVal;
      if (strobe.kind == KIND_SSCR) sScr <= newVal;
      if (strobe.kind == KIND_USCR) uScr <= newVal;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic hit;
    assign hit = strobe.wrEn && (strobe.kind == KIND_MCNTH) && (cntSel == 5'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    cntHi[g] <= '0;
      else if (hit) cntHi[g] <= newVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdWe      <= 1'b0;
      rdIdx     <= '0;
      rdData    <= '0;
      excValid  <= 1'b0;
      excCode   <= '0;
      excReason <= '0;
      excTval   <= '0;
    end else begin
      rdWe     <= strobe.rdWe;
      excValid <= strobe.excRaise;
      if (strobe.respond) begin
        rdIdx     <= reqRdIdx;
        rdData    <= oldVal;
        excReason <= strobe.reason;
        excCode   <= strobe.excRaise ? EXC_CODE_ILLEGAL : 5'd0;
        excTval   <= strobe.excRaise ? reqInsn : '0;
      end
    end
  end

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          ILEN    = 32,
  parameter logic [31:0] HART_ID = 32'h0000_0007
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [11:0]      reqAddr,
  input  logic [4:0]       reqSrcIdx,
  input  logic [XLEN-1:0]  reqSrcVal,
  input  logic [4:0]       reqRdIdx,
  input  logic [ILEN-1:0]  reqInsn,
  input  logic [1:0]       privMode,
  output logic             rdWe,
  output logic [4:0]       rdIdx,
  output logic [XLEN-1:0]  rdData,
  output logic             excValid,
  output logic [4:0]       excCode,
  output logic [1:0]       excReason,
  output logic [ILEN-1:0]  excTval
);

  ctrlStrobe_t strobe;

  csr_rmw_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqSrcIdx(reqSrcIdx),
    .reqRdIdx (reqRdIdx),
    .privMode (privMode),
    .strobe   (strobe)
  );

  csr_rmw_dp #(
    .XLEN   (XLEN),
    .ILEN   (ILEN),
    .HART_ID(HART_ID)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqSrcIdx(reqSrcIdx),
    .reqSrcVal(reqSrcVal),
    .reqRdIdx (reqRdIdx),
    .reqInsn  (reqInsn),
    .rdWe     (rdWe),
    .rdIdx    (rdIdx),
    .rdData   (rdData),
    .excValid (excValid),
    .excCode  (excCode),
    .excReason(excReason),
    .excTval  (excTval)
  );

endmodule

// File: rtl/csr_rmw_chk.sv
module csr_rmw_chk #(
  parameter int ILEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [11:0]     reqAddr,
  input logic [4:0]      reqSrcIdx,
  input logic [ILEN-1:0] reqInsn,
  input logic [1:0]      privMode,
  input logic            rdWe,
  input logic [4:0]      rdIdx,
  input logic            excValid,
  input logic [4:0]      excCode,
  input logic [ILEN-1:0] excTval
);

  // R12: an idle cycle yields no response on the next edge
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rdWe && !excValid));

  // R9: an exception never comes with a destination write
  a_r9_exc_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(rdWe && excValid));

  // R11: destination write never targets index zero
  a_r11_no_x0_write: assert property (@(posedge clk) disable iff (!rstN)
    rdWe |-> (rdIdx != 5'd0));

  // R9: trap value and cause code follow the faulting request
  a_r9_tval: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (!excValid || (excTval == $past(reqInsn) && excCode == 5'd2)));

  // R7: insufficient privilege always ends in an exception
  a_r7_priv_trap: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && privMode < reqAddr[9:8]) |=> excValid);

  // R8: write intent on a read-only address always ends in an exception
  a_r8_ro_trap: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[11:10] == 2'b11 && reqSrcIdx != 5'd0) |=> excValid);

endmodule

bind csr_rmw_unit csr_rmw_chk #(.ILEN(ILEN)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .reqSrcIdx(reqSrcIdx),
  .reqInsn  (reqInsn),
  .privMode (privMode),
  .rdWe     (rdWe),
  .rdIdx    (rdIdx),
  .excValid (excValid),
  .excCode  (excCode),
  .excTval  (excTval)
);

// File: tb/test_csr_rmw_unit.sv
`timescale 1ns/1ps
module test_csr_rmw_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = '0;
  logic [11:0] reqAddr = '0;
  logic [4:0]  reqSrcIdx = '0;
  logic [31:0] reqSrcVal = '0;
  logic [4:0]  reqRdIdx = '0;
  logic [31:0] reqInsn = '0;
  logic [1:0]  privMode = '0;
  logic        rdWe;
  logic [4:0]  rdIdx;
  logic [31:0] rdData;
  logic        excValid;
  logic [4:0]  excCode;
  logic [1:0]  excReason;
  logic [31:0] excTval;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  csr_rmw_unit i_csr_rmw_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqSrcIdx(reqSrcIdx), .reqSrcVal(reqSrcVal), .reqRdIdx(reqRdIdx), .reqInsn(reqInsn),
    .privMode(privMode), .rdWe(rdWe), .rdIdx(rdIdx), .rdData(rdData), .excValid(excValid),
    .excCode(excCode), .excReason(excReason), .excTval(excTval)
  );

  typedef struct packed {
    logic [3:0]  tag;   // requirement number printed on failure
    logic [1:0]  op;
    logic [1:0]  priv;
    logic [11:0] addr;
    logic [4:0]  src;
    logic [31:0] val;
    logic [4:0]  rd;
    logic [1:0]  exc;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  2'd0, 2'd3, 12'h340, 5'd1,  32'hA5A5_0000, 5'd5,  2'd0, 32'h0},           // R1 R2
    '{4'd5,  2'd0, 2'd3, 12'h340, 5'd0,  32'hFFFF_FFFF, 5'd6,  2'd0, 32'hA5A5_0000},   // R5
    '{4'd3,  2'd1, 2'd3, 12'h340, 5'd2,  32'h0500_0000, 5'd7,  2'd0, 32'hA5A5_0000},   // R3
    '{4'd5,  2'd2, 2'd3, 12'h340, 5'd0,  32'hFFFF_FFFF, 5'd8,  2'd0, 32'hA0A5_0000},   // R3 R5
    '{4'd4,  2'd2, 2'd3, 12'h340, 5'h13, 32'hFFFF_FFFF, 5'd9,  2'd0, 32'hA0A5_0000},   // R4
    '{4'd4,  2'd3, 2'd3, 12'h340, 5'h1F, 32'hFFFF_FFFF, 5'd10, 2'd0, 32'hA0A5_0013},   // R4
    '{4'd3,  2'd0, 2'd3, 12'h340, 5'd0,  32'h0,         5'd11, 2'd0, 32'hA0A5_0000},   // R3
    '{4'd2,  2'd0, 2'd3, 12'hB85, 5'd3,  32'h1234_5678, 5'd12, 2'd0, 32'h0},           // R2
    '{4'd10, 2'd0, 2'd0, 12'hC85, 5'd0,  32'h0,         5'd13, 2'd0, 32'h1234_5678},   // R10
    '{4'd8,  2'd0, 2'd0, 12'hC85, 5'd4,  32'h1,         5'd14, 2'd3, 32'h0},           // R8
    '{4'd8,  2'd2, 2'd0, 12'hC85, 5'd0,  32'h0,         5'd14, 2'd0, 32'h1234_5678},   // R8
    '{4'd7,  2'd0, 2'd0, 12'h340, 5'd1,  32'hFFFF_FFFF, 5'd1,  2'd2, 32'h0},           // R7
    '{4'd6,  2'd0, 2'd0, 12'h7C0, 5'd1,  32'h0,         5'd1,  2'd1, 32'h0},           // R6
    '{4'd10, 2'd0, 2'd0, 12'hC80, 5'd0,  32'h0,         5'd1,  2'd1, 32'h0},           // R10
    '{4'd2,  2'd0, 2'd1, 12'h140, 5'd1,  32'h0000_00F0, 5'd15, 2'd0, 32'h0},           // R2
    '{4'd3,  2'd1, 2'd1, 12'h140, 5'd1,  32'h0000_0030, 5'd15, 2'd0, 32'h0000_00F0},   // R3
    '{4'd3,  2'd0, 2'd1, 12'h140, 5'd0,  32'h0,         5'd15, 2'd0, 32'h0000_00C0},   // R3
    '{4'd7,  2'd0, 2'd0, 12'h800, 5'd1,  32'h1,         5'd1,  2'd0, 32'h0},           // R7
    '{4'd2,  2'd0, 2'd0, 12'h800, 5'd0,  32'h0,         5'd2,  2'd0, 32'h1},           // R2
    '{4'd12, 2'd0, 2'd3, 12'hF14, 5'd0,  32'h0,         5'd2,  2'd0, 32'h7},           // R12
    '{4'd8,  2'd0, 2'd3, 12'hF14, 5'd1,  32'h0,         5'd2,  2'd3, 32'h0},           // R8
    '{4'd7,  2'd0, 2'd0, 12'hF14, 5'd1,  32'h0,         5'd2,  2'd2, 32'h0},           // R7 priority
    '{4'd6,  2'd0, 2'd0, 12'h3FF, 5'd1,  32'h0,         5'd2,  2'd1, 32'h0},           // R6 priority
    '{4'd10, 2'd0, 2'd3, 12'hB9F, 5'd1,  32'hDEAD_0000, 5'd4,  2'd0, 32'h0},           // R10
    '{4'd10, 2'd0, 2'd0, 12'hC9F, 5'd0,  32'h0,         5'd4,  2'd0, 32'hDEAD_0000},   // R10
    '{4'd10, 2'd0, 2'd0, 12'hCA0, 5'd0,  32'h0,         5'd4,  2'd1, 32'h0},           // R10
    '{4'd9,  2'd0, 2'd3, 12'h340, 5'd0,  32'h0,         5'd3,  2'd0, 32'hA0A5_0000},   // R9
    '{4'd9,  2'd0, 2'd0, 12'hC85, 5'd0,  32'h0,         5'd3,  2'd0, 32'h1234_5678}    // R9
  };

  function automatic logic [31:0] mkInsn(input logic [1:0] op, input logic [11:0] a,
                                         input logic [4:0] s, input logic [4:0] d);
    return {a, s, op[1], 1'b1, op[0], d, 7'h73};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, expv);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] pv, input logic [11:0] a,
                       input logic [4:0] s, input logic [31:0] v, input logic [4:0] d);
    reqValid  = 1'b1;
    reqOp     = op;
    privMode  = pv;
    reqAddr   = a;
    reqSrcIdx = s;
    reqSrcVal = v;
    reqRdIdx  = d;
    reqInsn   = mkInsn(op, a, s, d);
    @(posedge clk);
    @(negedge clk);
    reqValid  = 1'b0;
  endtask

  task automatic expectOk(input string req, input logic [4:0] d, input logic [31:0] e);
    check(excValid == 1'b0, req, 32'(excValid), 32'h0);
    check(rdWe == 1'b1, req, 32'(rdWe), 32'h1);
    check(rdIdx == d, req, 32'(rdIdx), 32'(d));
    check(rdData == e, req, rdData, e);
  endtask

  task automatic expectExc(input string req, input logic [1:0] r, input logic [31:0] insn);
    check(excValid == 1'b1, req, 32'(excValid), 32'h1);
    check(rdWe == 1'b0, req, 32'(rdWe), 32'h0);
    check(excReason == r, req, 32'(excReason), 32'(r));
    check(excCode == 5'd2, req, 32'(excCode), 32'h2);
    check(excTval == insn, req, excTval, insn);
  endtask

  initial begin
    #(200000 * 10);
    compared++;
    mismatched++;
    $display("FAIL R12 watchdog expired: actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs quiet while in reset
    check(rdWe == 1'b0 && excValid == 1'b0, "R12 reset", {30'd0, rdWe, excValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdWe == 1'b0 && excValid == 1'b0, "R12 idle", {30'd0, rdWe, excValid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tagStr;
      v = VECS[i];
      tagStr = $sformatf("R%0d vec%0d", v.tag, i);
      issue(v.op, v.priv, v.addr, v.src, v.val, v.rd);
      if (v.exc != 2'd0) expectExc(tagStr, v.exc, mkInsn(v.op, v.addr, v.src, v.rd));
      else               expectOk(tagStr, v.rd, v.exp);
    end

    // R11: destination x0 suppresses rdWe but the write still lands
    issue(2'd0, 2'd3, 12'h340, 5'd1, 32'h0000_0001, 5'd0);
    check(rdWe == 1'b0, "R11 x0 rdWe", 32'(rdWe), 32'h0);
    check(excValid == 1'b0, "R11 x0 exc", 32'(excValid), 32'h0);
    issue(2'd0, 2'd3, 12'h340, 5'd0, 32'h0, 5'd9);
    expectOk("R11 readback", 5'd9, 32'hA0A5_0001);

    // R12: a cycle without a request gives no response
    @(negedge clk);
    check(rdWe == 1'b0 && excValid == 1'b0, "R12 no-request", {30'd0, rdWe, excValid}, 32'h0);

    // R12: reset clears the writable registers
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    issue(2'd0, 2'd3, 12'h340, 5'd0, 32'h0, 5'd1);
    expectOk("R12 cleared scratch", 5'd1, 32'h0);
    issue(2'd0, 2'd0, 12'hC85, 5'd0, 32'h0, 5'd1);
    expectOk("R12 cleared counter alias", 5'd1, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule